// File: doc/BRIEF.md
# IPv4 Header Fast-Path Checker and Rewriter

This block receives the fixed 20-byte part of an IPv4 header as a stream of equal-width words over a valid/ready handshake. Once the last word has arrived, it decides whether the packet can take the hardware fast path. If it can, the block lowers the time-to-live by one, or leaves it unchanged when route lookup marks the packet as addressed to this router. It then writes a freshly computed header checksum and presents the rewritten header together with a fast/slow decision and a reason code.

Headers that fail a test leave the block unmodified and are marked for slow-path software. The checksum that arrives with the header is never verified, so the check costs no cycles and no adder. Only one header is in flight at a time: the input stays closed from the moment the last word is taken until the result has been consumed.

Top module: `ipv4_fastpath`

## Requirements
- R1: The header is sent as 160/W words, most significant bytes first, so header byte 0 (version in its upper nibble, header-length in its lower nibble) sits in bits [W-1:W-8] of the first word. Every output header bit outside the TTL byte (out_hdr[95:88]) and the checksum field (out_hdr[79:64]) equals the received header.
- R2: A version nibble (out_hdr[159:156]) other than 4 gives a slow decision with reason 1.
- R3: A header-length nibble (out_hdr[155:152]) below 5, or a total length (bytes 2–3, [143:128]) smaller than four times the header length, gives reason 2.
- R4: A header-length nibble above 5 (options present) gives reason 3.
- R5: A destination address (bytes 16–19, [31:0]) whose top four bits are 1110 gives reason 4.
- R6: A total length greater than the parameter MTU (default 1500) gives reason 6. A total length equal to MTU is allowed.
- R7: A transit packet (in_local low) with TTL 0 or 1 gives reason 5. A local packet with any TTL is not rejected for its TTL.
- R8: When several tests fail, the reported reason follows the priority 1, 2, 3, 4, 6, 5. Reason 0 appears if and only if the decision is fast.
- R9: On the fast path the TTL is decremented by one for transit packets and left unchanged for local packets. A slow-path header is output exactly as received.
- R10: On the fast path the checksum field holds the ones'-complement of the end-around-carry sum of the ten 16-bit header words, taken with the checksum field as zero. The incoming checksum value has no effect on the result.
- R11: While out_valid is high and out_ready is low, out_hdr, out_fast and out_reason hold their values and in_ready stays low. A new header is accepted only after the previous result has been consumed.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | W | Header word, most significant bytes first |
| in_local | input | 1 | Packet addressed to this router; sampled with the last word |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_hdr | output | 160 | Rewritten (fast) or original (slow) header |
| out_fast | output | 1 | 1 = fast path, 0 = slow path |
| out_reason | output | 3 | 0 ok, 1 version, 2 length, 3 options, 4 multicast, 5 TTL expired, 6 fragmentation needed |

## Verification
The hardest situations to reach are the ones where several tests fail at once, because only the winning reason is visible at the ports. The bench builds headers that combine two or three faults: wrong version with options, options with a multicast destination, multicast with an oversize length and an expiring TTL, and oversize length with an expiring TTL. Each of these checks that the reason with the higher priority is reported. The bench also sends the same header twice with different incoming checksums and compares the two outputs. Finally it holds out_ready low across several cycles, which shows the output stays stable and the input stays closed.

// File: rtl/ipv4fp_pkg.sv
package ipv4fp_pkg;

   localparam int HDR_BITS  = 160;
   localparam int HDR_HALFS = HDR_BITS / 16;

   typedef enum logic [2:0] {
      RSN_OK    = 3'd0,
      RSN_VER   = 3'd1,
      RSN_LEN   = 3'd2,
      RSN_OPT   = 3'd3,
      RSN_MCAST = 3'd4,
      RSN_TTL   = 3'd5,
      RSN_FRAG  = 3'd6
   } fp_reason_e;

   // folded ones'-complement sum of all 16-bit words of a header
   function automatic logic [15:0] ones_fold(input logic [HDR_BITS-1:0] h);
      logic [31:0] s;
      s = 32'd0;
      for (int i = 0; i < HDR_HALFS; i++) begin
         s = s + {16'd0, h[HDR_BITS-1-16*i -: 16]};
      end
      s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
      s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
      return s[15:0];
   endfunction

endpackage

// File: rtl/ipv4fp_collect.sv
module ipv4fp_collect
   import ipv4fp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [W-1:0]        in_data,
   input  logic                in_local,
   input  logic                blocked,
   input  logic                take,
   output logic                in_ready,
   output logic                full,
   output logic [HDR_BITS-1:0] hdr,
   output logic                local_o
);

   localparam int NWORDS = HDR_BITS / W;
   localparam int CNT_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NWORDS - 1);

   logic [CNT_W-1:0]    cnt;
   logic [HDR_BITS-1:0] hdr_r;
   logic                full_r;
   logic                local_r;
   logic                acc;
   logic                last;

   initial begin
      assert (W >= 8 && (HDR_BITS % W) == 0)
         else $error("ipv4fp_collect: W must divide the header width");
   end

   assign in_ready = !full_r && !blocked;
   assign acc      = in_valid && in_ready;
   assign last     = (cnt == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         full_r  <= 1'b0;
         local_r <= 1'b0;
      end else begin
         if (acc) begin
            cnt <= last ? '0 : cnt + 1'b1;
            if (last) begin
               full_r  <= 1'b1;
               local_r <= in_local;
            end
         end
         if (take) full_r <= 1'b0;
      end
   end

   generate
      if (NWORDS == 1) begin : g_whole
         always_ff @(posedge clk) begin
            if (!rst_n)   hdr_r <= '0;
            else if (acc) hdr_r <= in_data;
         end
      end else begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n)   hdr_r <= '0;
            else if (acc) hdr_r <= {hdr_r[HDR_BITS-W-1:0], in_data};
         end
      end
   endgenerate

   assign full    = full_r;
   assign hdr     = hdr_r;
   assign local_o = local_r;

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_IDX);

   // R11
   take_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full_r);

endmodule

// File: rtl/ipv4fp_check.sv
module ipv4fp_check
   import ipv4fp_pkg::*;
#(
   parameter int MTU = 1500
) (
   input  logic [3:0]  ver,
   input  logic [3:0]  ihl,
   input  logic [15:0] tlen,
   input  logic [7:0]  ttl,
   input  logic [3:0]  dst_top,
   input  logic        is_local,
   output fp_reason_e  reason,
   output logic        fast
);

   localparam logic [15:0] MTU16 = 16'(MTU);

   initial begin
      assert (MTU >= 20 && MTU <= 65535)
         else $error("ipv4fp_check: MTU out of range");
   end

   logic bad_ver, bad_len, has_opt, is_mcast, too_big, ttl_dead;

   always_comb begin
      bad_ver  = (ver != 4'd4);
      bad_len  = (ihl < 4'd5) || (tlen < {10'd0, ihl, 2'b00});
      has_opt  = (ihl > 4'd5);
      is_mcast = (dst_top == 4'hE);
      too_big  = (tlen > MTU16);
      ttl_dead = !is_local && (ttl <= 8'd1);

      if (bad_ver)       reason = RSN_VER;
      else if (bad_len)  reason = RSN_LEN;
      else if (has_opt)  reason = RSN_OPT;
      else if (is_mcast) reason = RSN_MCAST;
      else if (too_big)  reason = RSN_FRAG;
      else if (ttl_dead) reason = RSN_TTL;
      else               reason = RSN_OK;

      fast = (reason == RSN_OK);
   end

   // R7
   ttl_local_chk: assert final ((reason != RSN_TTL) || !is_local);

endmodule

// File: rtl/ipv4fp_csum.sv
module ipv4fp_csum
   import ipv4fp_pkg::*;
(
   input  logic [HDR_BITS-1:0] hdr_zeroed,
   output logic [15:0]         csum
);

   localparam int ACC_W = 16 + $clog2(HDR_HALFS + 1);

   logic [ACC_W-1:0] acc [0:HDR_HALFS];
   logic [16:0]      f1;
   logic [15:0]      f2;

   assign acc[0] = '0;

   generate
      for (genvar i = 0; i < HDR_HALFS; i++) begin : g_add
         assign acc[i+1] = acc[i] + ACC_W'(hdr_zeroed[HDR_BITS-1-16*i -: 16]);
      end
   endgenerate

   assign f1   = {1'b0, acc[HDR_HALFS][15:0]} + 17'(acc[HDR_HALFS][ACC_W-1:16]);
   assign f2   = f1[15:0] + {15'd0, f1[16]};
   assign csum = ~f2;

endmodule

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath
   import ipv4fp_pkg::*;
#(
   parameter int W   = 32,
   parameter int MTU = 1500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [W-1:0]        in_data,
   input  logic                in_local,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [HDR_BITS-1:0] out_hdr,
   output logic                out_fast,
   output logic [2:0]          out_reason
);

   logic                full, take, is_local, fast;
   logic [HDR_BITS-1:0] hdr, mod_hdr;
   logic [7:0]          ttl_in, ttl_new;
   logic [15:0]         csum;
   fp_reason_e          reason;

   ipv4fp_collect #(.W(W)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_local (in_local),
      .blocked  (out_valid),
      .take     (take),
      .in_ready (in_ready),
      .full     (full),
      .hdr      (hdr),
      .local_o  (is_local)
   );

   assign ttl_in = hdr[95:88];

   ipv4fp_check #(.MTU(MTU)) u_check (
      .ver      (hdr[159:156]),
      .ihl      (hdr[155:152]),
      .tlen     (hdr[143:128]),
      .ttl      (ttl_in),
      .dst_top  (hdr[31:28]),
      .is_local (is_local),
      .reason   (reason),
      .fast     (fast)
   );

   assign ttl_new = is_local ? ttl_in : ttl_in - 8'd1;
   assign mod_hdr = {hdr[159:96], ttl_new, hdr[87:80], 16'd0, hdr[63:0]};

   ipv4fp_csum u_csum (
      .hdr_zeroed (mod_hdr),
      .csum       (csum)
   );

   assign take = full && !out_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_hdr    <= '0;
         out_fast   <= 1'b0;
         out_reason <= 3'd0;
      end else if (take) begin
         out_valid  <= 1'b1;
         out_hdr    <= fast ? {mod_hdr[159:80], csum, mod_hdr[63:0]} : hdr;
         out_fast   <= fast;
         out_reason <= reason;
      end else if (out_valid && out_ready) begin
         out_valid  <= 1'b0;
      end
   end

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_hdr)
                                  && $stable(out_fast) && $stable(out_reason));

   // R11
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R10
   csum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_fast |-> ones_fold(out_hdr) == 16'hFFFF);

   // R2
   fast_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_fast |-> out_hdr[159:156] == 4'd4 && out_hdr[155:152] == 4'd5);

   // R5
   fast_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_fast |-> out_hdr[31:28] != 4'hE);

   // R8
   reason_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_fast == (out_reason == 3'd0));

endmodule

// File: tb/sim_ipv4_fastpath.sv
module sim_ipv4_fastpath;

   localparam int W  = 32;
   localparam int NW = 160 / W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [W-1:0] in_data = '0;
   logic         in_local = 1'b0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [159:0] out_hdr;
   logic         out_fast;
   logic [2:0]   out_reason;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   ipv4_fastpath #(.W(W), .MTU(1500)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_local(in_local), .out_valid(out_valid),
      .out_ready(out_ready), .out_hdr(out_hdr), .out_fast(out_fast),
      .out_reason(out_reason)
   );

   function automatic logic [159:0] mk(input logic [3:0] ver, input logic [3:0] ihl,
                                       input logic [15:0] tlen, input logic [7:0] ttl,
                                       input logic [31:0] dst, input logic [15:0] cs);
      return {ver, ihl, 8'h00, tlen, 16'h1c46, 16'h4000, ttl, 8'd6, cs, 32'hc0a80001, dst};
   endfunction

   function automatic logic [15:0] bench_csum(input logic [159:0] h);
      logic [159:0] z;
      int unsigned  s;
      z = h;
      z[79:64] = 16'd0;
      s = 0;
      for (int i = 0; i < 10; i++) s = s + z[159-16*i -: 16];
      while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
      return ~s[15:0];
   endfunction

   function automatic logic [159:0] rewrite(input logic [159:0] h, input logic loc);
      logic [159:0] r;
      r = h;
      if (!loc) r[95:88] = h[95:88] - 8'd1;
      r[79:64] = bench_csum(r);
      return r;
   endfunction

   task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [159:0] h, input logic loc);
      for (int i = 0; i < NW; i++) begin
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_data  = h[159-W*i -: W];
         in_local = loc;
         @(negedge clk);
      end
      in_valid = 1'b0;
      while (!out_valid) @(negedge clk);
   endtask

   task automatic consume;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   // sends one header, checks the header and the decision, consumes the result
   task automatic run_case(input string req, input logic [159:0] h, input logic loc,
                           input logic [2:0] exp_reason);
      logic [159:0] exp_h;
      logic         exp_fast;
      exp_fast = (exp_reason == 3'd0);
      exp_h    = exp_fast ? rewrite(h, loc) : h;
      send(h, loc);
      check({req, " header"}, out_hdr, exp_h);
      check({req, " decision"}, {156'd0, out_fast, out_reason}, {156'd0, exp_fast, exp_reason});
      consume();
   endtask

   task automatic t_reset;
      check("R12 out_valid", {159'd0, out_valid}, 160'd0);
      check("R12 in_ready", {159'd0, in_ready}, 160'd1);
   endtask

   task automatic t_transit;
      run_case("R1 R9 transit", mk(4, 5, 16'd60, 8'd64, 32'h0a000005, 16'hdead), 1'b0, 3'd0);
      run_case("R9 transit ttl2", mk(4, 5, 16'd20, 8'd2, 32'h0a010203, 16'h0000), 1'b0, 3'd0);
   endtask

   task automatic t_csum_ignored;
      logic [159:0] a;
      send(mk(4, 5, 16'd100, 8'd30, 32'h08080808, 16'h1234), 1'b0);
      a = out_hdr;
      consume();
      send(mk(4, 5, 16'd100, 8'd30, 32'h08080808, 16'hffff), 1'b0);
      check("R10 incoming csum ignored", out_hdr, a);
      consume();
   endtask

   task automatic t_local;
      run_case("R7 R9 local ttl1", mk(4, 5, 16'd40, 8'd1, 32'h0a000001, 16'h0), 1'b1, 3'd0);
      run_case("R7 R9 local ttl0", mk(4, 5, 16'd40, 8'd0, 32'h0a000001, 16'h0), 1'b1, 3'd0);
   endtask

   task automatic t_faults;
      run_case("R7 ttl1", mk(4, 5, 16'd40, 8'd1, 32'h0a000001, 16'h0), 1'b0, 3'd5);
      run_case("R7 ttl0", mk(4, 5, 16'd40, 8'd0, 32'h0a000001, 16'h0), 1'b0, 3'd5);
      run_case("R2 ver6", mk(6, 5, 16'd40, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd1);
      run_case("R3 ihl4", mk(4, 4, 16'd40, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd2);
      run_case("R3 tlen19", mk(4, 5, 16'd19, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd2);
      run_case("R4 ihl6", mk(4, 6, 16'd40, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd3);
      run_case("R5 mcast224", mk(4, 5, 16'd40, 8'd9, 32'he0000001, 16'h0), 1'b0, 3'd4);
      run_case("R5 mcast239", mk(4, 5, 16'd40, 8'd9, 32'hefffffff, 16'h0), 1'b0, 3'd4);
      run_case("R5 not mcast 240", mk(4, 5, 16'd40, 8'd9, 32'hf0000001, 16'h0), 1'b0, 3'd0);
      run_case("R6 tlen1501", mk(4, 5, 16'd1501, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd6);
      run_case("R6 tlen1500", mk(4, 5, 16'd1500, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd0);
   endtask

   task automatic t_priority;
      run_case("R8 ver over opt", mk(6, 6, 16'd40, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd1);
      run_case("R8 opt over mcast", mk(4, 6, 16'd40, 8'd9, 32'he0000001, 16'h0), 1'b0, 3'd3);
      run_case("R8 mcast over frag ttl", mk(4, 5, 16'd2000, 8'd1, 32'he0000001, 16'h0), 1'b0, 3'd4);
      run_case("R8 frag over ttl", mk(4, 5, 16'd2000, 8'd1, 32'h0a000001, 16'h0), 1'b0, 3'd6);
      run_case("R8 len over opt", mk(4, 7, 16'd24, 8'd9, 32'h0a000001, 16'h0), 1'b0, 3'd2);
   endtask

   task automatic t_stall;
      logic [159:0] h, first;
      h = mk(4, 5, 16'd576, 8'd128, 32'h0b0c0d0e, 16'h5555);
      send(h, 1'b0);
      first = out_hdr;
      check("R11 stall header", first, rewrite(h, 1'b0));
      for (int k = 0; k < 4; k++) begin
         in_valid = 1'b1;
         in_data  = '1;
         @(negedge clk);
         check("R11 held header", out_hdr, first);
         check("R11 held valid/ready", {158'd0, out_valid, in_ready}, {158'd0, 1'b1, 1'b0});
      end
      in_valid = 1'b0;
      consume();
      check("R11 released", {158'd0, out_valid, in_ready}, {158'd0, 1'b0, 1'b1});
      run_case("R11 after stall", mk(4, 5, 16'd20, 8'd5, 32'h01020304, 16'h0), 1'b0, 3'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_transit();
      t_csum_ignored();
      t_local();
      t_faults();
      t_priority();
      t_stall();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule